// File: doc/BRIEF.md
# NOR Flash Write-Command Sequencer

This block decodes the bus writes that a host makes to a parallel NOR flash using the classic two-step-unlock command set. Each write brings a byte offset and a data word. The block reduces the offset to a word address for the configured bus width. It follows the unlock handshake and the chosen command, and emits one-cycle requests to a separate erase/program engine: program (with the merged data word), sector erase, chip erase, erase suspend and erase resume.

The block also owns the read-side mode: plain array data, identification data, engine status, or the query table. It steers a read data mux that way. It supports fast (bypass) command entry and query entry from plain read or from identification mode, with a reset that returns to whichever of the two it came from. Reset writes are refused while the engine is busy.

The engine reports back whether the sector-erase acceptance window is open, whether an erase is suspended, whether the addressed sector is among those being erased, and when the running operation completes. Erase timing, the array storage and the query table contents live outside.

Top module: `flash_cmd_seq`

## Requirements
- R1: The command word address is the write byte offset shifted right by log2(BUS_BYTES), and only its low 11 bits are compared. With a 2-byte bus, byte offsets 0xAAA, 0xAAB and 0x1AAA all hit word 0x555.
- R2: The write 0xAA to unlock word UA0 (default 0x555), then 0x55 to UA1 (default 0x2AA), then a command byte to UA0 selects the command: 0x90 enters identification mode, 0xA0 arms a program, 0x80 starts the erase sequence, 0x20 enters bypass. The read_mode encoding is 0 array, 1 identification, 2 status, 3 query.
- R3: A write with the wrong address or data at any unlock or command step returns to plain read and clears bypass.
- R4: An erase needs a second 0xAA/0x55 pair after 0x80. The sixth write is either 0x10 to UA0, which raises req_chip, or 0x30 to any address, which raises req_sector with that byte offset. Either choice sets read_mode to status. 0x10 to any other word resets.
- R5: In bypass, each command is taken straight from the command step without unlock writes and without an address check. After a program the block returns to the command step. Writing 0x00 in identification mode leaves bypass.
- R6: 0x98 to word 0x55 from plain read enters query mode, and 0xF0 then returns to plain read. From identification mode the same write enters query mode, and 0xF0 returns to identification mode. Any other write in query mode resets.
- R7: 0xF0 resets the sequence except while a program is armed or a chip or sector erase is in progress. In those states it is ignored, or it is taken as program data.
- R8: During a sector erase with the acceptance window open, 0x30 queues another sector (req_sector) and any other value except 0xB0 resets. Once the window is closed, writes are ignored. 0xB0 at any time during the erase raises req_suspend and returns to array mode.
- R9: In plain read, 0xB0 is ignored. 0x30 raises req_resume and sets status mode if an erase is suspended; otherwise it resets.
- R10: While an erase is suspended, a new erase command resets without a request. A program to a sector under erase produces no req_prog.
- R11: A program raises req_prog for one cycle, with req_addr set to the write offset and req_data set to the write data ANDed with arr_q. The block then returns to array mode.
- R12: In identification mode, read word 0 returns ID0, word 1 returns ID1 and word 2 returns 0. Words 0x0E and 0x0F return ID2 and ID3 unless that value's low byte is 0xFF, in which case array data is returned. Other words return array data.
- R13: eng_done ends a chip or sector erase and returns to plain read (to the command step in bypass). A write in the same cycle is discarded.
- R14: Reset gives array mode and no requests. Every request is a single-cycle pulse, at most one at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously upstream |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | DW | Write data; low byte is the command |
| arr_q | input | DW | Array contents at wr_addr, for the program merge |
| eng_window | input | 1 | Sector-erase acceptance window open |
| eng_suspended | input | 1 | An erase is suspended |
| eng_sect_hit | input | 1 | Sector of wr_addr is being erased |
| eng_done | input | 1 | Running erase finished (pulse) |
| req_prog | output | 1 | Program request pulse |
| req_sector | output | 1 | Sector erase request pulse |
| req_chip | output | 1 | Chip erase request pulse |
| req_suspend | output | 1 | Erase suspend request pulse |
| req_resume | output | 1 | Erase resume request pulse |
| req_addr | output | ADDR_W | Byte offset of the last program or sector request |
| req_data | output | DW | Merged program data |
| read_mode | output | 2 | 0 array, 1 identification, 2 status, 3 query |
| rd_addr | input | 8 | Low byte of the read byte offset |
| rd_arr | input | DW | Array read data |
| rd_status | input | DW | Engine status word |
| rd_cfi | input | DW | Query table word |
| rd_data | output | DW | Read data selected by read_mode |

## Verification
Two events can land in the same clock: the engine's completion pulse and a host write aimed at the running erase, such as a suspend or another sector command. The bench raises eng_done in the very cycle it writes 0xB0 during a running sector erase. The run is judged correct only if no suspend pulse appears and the mode falls straight to array, so completion wins and the write is dropped. The bench also drives 0xF0 in the acceptance window and in the running phase, to separate the "other value resets" rule from the "ignored while busy" rule.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [3:0] {
    S_READ, S_UNL1, S_CMD, S_PROG, S_AUTO,
    S_EUNL0, S_EUNL1, S_ECMD, S_CHIP, S_SECT,
    S_QRY, S_AQRY
  } seq_state_e;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_ID     = 2'd1,
    RM_STATUS = 2'd2,
    RM_QUERY  = 2'd3
  } rd_mode_e;

  typedef struct packed {
    logic prog;
    logic sector;
    logic chip;
    logic suspend;
    logic resume;
  } req_t;

  localparam logic [7:0] K_UNLK_A  = 8'hAA;
  localparam logic [7:0] K_UNLK_B  = 8'h55;
  localparam logic [7:0] K_ERASE   = 8'h80;
  localparam logic [7:0] K_IDENT   = 8'h90;
  localparam logic [7:0] K_PROG    = 8'hA0;
  localparam logic [7:0] K_FAST    = 8'h20;
  localparam logic [7:0] K_CHIP    = 8'h10;
  localparam logic [7:0] K_SECT    = 8'h30;
  localparam logic [7:0] K_SUSP    = 8'hB0;
  localparam logic [7:0] K_RESET   = 8'hF0;
  localparam logic [7:0] K_QUERY   = 8'h98;
  localparam logic [7:0] K_FASTEND = 8'h00;
  localparam logic [10:0] QUERY_WORD = 11'h055;

  function automatic rd_mode_e mode_of(seq_state_e s);
    case (s)
      S_AUTO:                  mode_of = RM_ID;
      S_PROG, S_CHIP, S_SECT:  mode_of = RM_STATUS;
      S_QRY, S_AQRY:           mode_of = RM_QUERY;
      default:                 mode_of = RM_ARRAY;
    endcase
  endfunction

endpackage

// File: rtl/fcd_addr_map.sv
module fcd_addr_map #(
  parameter int IN_W      = 20,
  parameter int BUS_BYTES = 2,
  parameter int OUT_W     = 11
) (
  input  logic [IN_W-1:0]  byte_addr,
  output logic [OUT_W-1:0] word_addr
);
  generate
    if (BUS_BYTES == 4) begin : g_quad
      assign word_addr = OUT_W'(byte_addr >> 2);
    end else if (BUS_BYTES == 2) begin : g_dual
      assign word_addr = OUT_W'(byte_addr >> 1);
    end else begin : g_single
      assign word_addr = OUT_W'(byte_addr);
    end
  endgenerate
endmodule

// File: rtl/fcd_read_mux.sv
module fcd_read_mux
  import fcd_pkg::*;
#(
  parameter int          DW  = 16,
  parameter logic [15:0] ID0 = 16'h0001,
  parameter logic [15:0] ID1 = 16'h227E,
  parameter logic [15:0] ID2 = 16'h2201,
  parameter logic [15:0] ID3 = 16'h00FF
) (
  input  logic [1:0]    mode,
  input  logic [7:0]    idx,
  input  logic [DW-1:0] rd_arr,
  input  logic [DW-1:0] rd_status,
  input  logic [DW-1:0] rd_cfi,
  output logic [DW-1:0] rd_data
);
  localparam bit ID2_LIVE = (ID2[7:0] != 8'hFF);
  localparam bit ID3_LIVE = (ID3[7:0] != 8'hFF);

  logic [DW-1:0] id_word;

  always_comb begin
    case (idx)
      8'h00:   id_word = DW'(ID0);
      8'h01:   id_word = DW'(ID1);
      8'h02:   id_word = '0;
      8'h0E:   id_word = ID2_LIVE ? DW'(ID2) : rd_arr;
      8'h0F:   id_word = ID3_LIVE ? DW'(ID3) : rd_arr;
      default: id_word = rd_arr;
    endcase
  end

  always_comb begin
    case (rd_mode_e'(mode))
      RM_ID:     rd_data = id_word;
      RM_STATUS: rd_data = rd_status;
      RM_QUERY:  rd_data = rd_cfi;
      default:   rd_data = rd_arr;
    endcase
  end
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int          ADDR_W = 20,
  parameter int          DW     = 16,
  parameter logic [10:0] UA0    = 11'h555,
  parameter logic [10:0] UA1    = 11'h2AA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [10:0]       wr_word,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [DW-1:0]     arr_q,
  input  logic              eng_window,
  input  logic              eng_suspended,
  input  logic              eng_sect_hit,
  input  logic              eng_done,
  output req_t              req,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DW-1:0]     req_data,
  output logic [1:0]        read_mode
);
  seq_state_e st_q, st_d;
  logic       byp_q, byp_d;
  rd_mode_e   mode_q, mode_d;
  req_t       req_q, req_d;
  logic       ld_en;
  logic [7:0] cmd;
  logic       at_ua0, at_ua1, at_qry, busy;

  assign cmd    = wr_data[7:0];
  assign at_ua0 = (wr_word == UA0);
  assign at_ua1 = (wr_word == UA1);
  assign at_qry = (wr_word == QUERY_WORD);
  assign busy   = (st_q == S_PROG) || (st_q == S_CHIP) || (st_q == S_SECT);

  always_comb begin
    st_d  = st_q;
    byp_d = byp_q;
    req_d = '0;
    if (eng_done && (st_q == S_CHIP || st_q == S_SECT)) begin
      st_d = byp_q ? S_CMD : S_READ;
    end else if (wr_en) begin
      if (cmd == K_RESET && !busy) begin
        if (st_q == S_AQRY) begin
          st_d = S_AUTO;
        end else begin
          st_d  = S_READ;
          byp_d = 1'b0;
        end
      end else begin
        st_d  = S_READ;
        byp_d = 1'b0;
        case (st_q)
          S_READ: begin
            if (at_qry && cmd == K_QUERY) begin
              st_d = S_QRY;
            end else if (cmd == K_SECT) begin
              if (eng_suspended) begin
                req_d.resume = 1'b1;
                st_d  = S_SECT;
                byp_d = byp_q;
              end
            end else if (cmd == K_SUSP) begin
              st_d  = st_q;
              byp_d = byp_q;
            end else if (at_ua0 && cmd == K_UNLK_A) begin
              st_d  = S_UNL1;
              byp_d = byp_q;
            end
          end
          S_UNL1: begin
            if (at_ua1 && cmd == K_UNLK_B) begin
              st_d  = S_CMD;
              byp_d = byp_q;
            end
          end
          S_CMD: begin
            if (byp_q || at_ua0) begin
              byp_d = byp_q;
              case (cmd)
                K_FAST:  begin st_d = S_CMD; byp_d = 1'b1; end
                K_ERASE: st_d = S_EUNL0;
                K_IDENT: st_d = S_AUTO;
                K_PROG:  st_d = S_PROG;
                default: begin st_d = S_READ; byp_d = 1'b0; end
              endcase
            end
          end
          S_PROG: begin
            req_d.prog = !(eng_suspended && eng_sect_hit);
            st_d  = byp_q ? S_CMD : S_READ;
            byp_d = byp_q;
          end
          S_AUTO: begin
            if (!(byp_q && cmd == K_FASTEND) && at_qry && cmd == K_QUERY) begin
              st_d  = S_AQRY;
              byp_d = byp_q;
            end
          end
          S_EUNL0: begin
            if (at_ua0 && cmd == K_UNLK_A) begin
              st_d  = S_EUNL1;
              byp_d = byp_q;
            end
          end
          S_EUNL1: begin
            if (at_ua1 && cmd == K_UNLK_B) begin
              st_d  = S_ECMD;
              byp_d = byp_q;
            end
          end
          S_ECMD: begin
            if (!eng_suspended) begin
              if (cmd == K_CHIP && at_ua0) begin
                req_d.chip = 1'b1;
                st_d  = S_CHIP;
                byp_d = byp_q;
              end else if (cmd == K_SECT) begin
                req_d.sector = 1'b1;
                st_d  = S_SECT;
                byp_d = byp_q;
              end
            end
          end
          S_CHIP: begin
            st_d  = st_q;
            byp_d = byp_q;
          end
          S_SECT: begin
            byp_d = byp_q;
            if (cmd == K_SUSP) begin
              req_d.suspend = 1'b1;
              st_d = S_READ;
            end else if (eng_window) begin
              if (cmd == K_SECT) begin
                req_d.sector = 1'b1;
                st_d = S_SECT;
              end else begin
                byp_d = 1'b0;
              end
            end else begin
              st_d = S_SECT;
            end
          end
          default: ;
        endcase
      end
    end
    mode_d = mode_of(st_d);
  end

  assign ld_en = req_d.prog | req_d.sector;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_READ;
      byp_q  <= 1'b0;
      mode_q <= RM_ARRAY;
      req_q  <= '0;
    end else begin
      st_q   <= st_d;
      byp_q  <= byp_d;
      mode_q <= mode_d;
      req_q  <= req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_addr <= '0;
      req_data <= '0;
    end else if (ld_en) begin
      req_addr <= wr_addr;
      req_data <= wr_data & arr_q;
    end
  end

  assign req       = req_q;
  assign read_mode = mode_q;

  p_single_req_r14: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_q.prog, req_q.sector, req_q.chip, req_q.suspend, req_q.resume}));

  p_chip_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_CHIP && !eng_done) |=> (st_q == S_CHIP));

  p_resume_needs_susp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_q.resume |-> $past(eng_suspended));

  p_suspend_to_array_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_q.suspend |-> (mode_q == RM_ARRAY));

  p_drop_hit_prog_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && st_q == S_PROG && eng_suspended && eng_sect_hit) |=> !req_q.prog);

  p_done_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && (st_q == S_SECT || st_q == S_CHIP)) |=> (req_q == '0));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcd_pkg::*;
#(
  parameter int          ADDR_W    = 20,
  parameter int          DW        = 16,
  parameter int          BUS_BYTES = 2,
  parameter logic [10:0] UA0       = 11'h555,
  parameter logic [10:0] UA1       = 11'h2AA,
  parameter logic [15:0] ID0       = 16'h0001,
  parameter logic [15:0] ID1       = 16'h227E,
  parameter logic [15:0] ID2       = 16'h2201,
  parameter logic [15:0] ID3       = 16'h00FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [DW-1:0]     arr_q,
  input  logic              eng_window,
  input  logic              eng_suspended,
  input  logic              eng_sect_hit,
  input  logic              eng_done,
  output logic              req_prog,
  output logic              req_sector,
  output logic              req_chip,
  output logic              req_suspend,
  output logic              req_resume,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DW-1:0]     req_data,
  output logic [1:0]        read_mode,
  input  logic [7:0]        rd_addr,
  input  logic [DW-1:0]     rd_arr,
  input  logic [DW-1:0]     rd_status,
  input  logic [DW-1:0]     rd_cfi,
  output logic [DW-1:0]     rd_data
);
  logic [10:0] wr_word;
  logic [7:0]  rd_idx;
  req_t        req;

  fcd_addr_map #(.IN_W(ADDR_W), .BUS_BYTES(BUS_BYTES), .OUT_W(11)) u_wmap (
    .byte_addr(wr_addr), .word_addr(wr_word));

  fcd_addr_map #(.IN_W(8), .BUS_BYTES(BUS_BYTES), .OUT_W(8)) u_rmap (
    .byte_addr(rd_addr), .word_addr(rd_idx));

  fcd_seq #(.ADDR_W(ADDR_W), .DW(DW), .UA0(UA0), .UA1(UA1)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
    .wr_addr(wr_addr), .wr_data(wr_data), .arr_q(arr_q),
    .eng_window(eng_window), .eng_suspended(eng_suspended),
    .eng_sect_hit(eng_sect_hit), .eng_done(eng_done),
    .req(req), .req_addr(req_addr), .req_data(req_data),
    .read_mode(read_mode));

  fcd_read_mux #(.DW(DW), .ID0(ID0), .ID1(ID1), .ID2(ID2), .ID3(ID3)) u_rmux (
    .mode(read_mode), .idx(rd_idx), .rd_arr(rd_arr), .rd_status(rd_status),
    .rd_cfi(rd_cfi), .rd_data(rd_data));

  assign req_prog    = req.prog;
  assign req_sector  = req.sector;
  assign req_chip    = req.chip;
  assign req_suspend = req.suspend;
  assign req_resume  = req.resume;
endmodule

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] arr_q = 16'hFFFF;
  logic        eng_window = 1'b0, eng_suspended = 1'b0, eng_sect_hit = 1'b0, eng_done = 1'b0;
  logic        req_prog, req_sector, req_chip, req_suspend, req_resume;
  logic [19:0] req_addr;
  logic [15:0] req_data;
  logic [1:0]  read_mode;
  logic [7:0]  rd_addr = '0;
  logic [15:0] rd_arr = 16'hBEEF, rd_status = 16'h0080, rd_cfi = 16'h0051;
  logic [15:0] rd_data;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [4:0]  got;   // {prog, sector, chip, suspend, resume}
  logic [19:0] got_addr;
  logic [15:0] got_data;

  always #2.5 clk = ~clk;

  flash_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .arr_q(arr_q), .eng_window(eng_window), .eng_suspended(eng_suspended),
    .eng_sect_hit(eng_sect_hit), .eng_done(eng_done),
    .req_prog(req_prog), .req_sector(req_sector), .req_chip(req_chip),
    .req_suspend(req_suspend), .req_resume(req_resume),
    .req_addr(req_addr), .req_data(req_data), .read_mode(read_mode),
    .rd_addr(rd_addr), .rd_arr(rd_arr), .rd_status(rd_status), .rd_cfi(rd_cfi),
    .rd_data(rd_data));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    got = {req_prog, req_sector, req_chip, req_suspend, req_resume};
    got_addr = req_addr; got_data = req_data;
  endtask

  task automatic done_pulse();
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
  endtask

  task automatic unlock();
    wr(20'h00AAA, 16'h00AA);
    wr(20'h00554, 16'h0055);
  endtask

  task automatic erase_prefix();
    unlock(); wr(20'h00AAA, 16'h0080); unlock();
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [15:0] exp);
    rd_addr = a; #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic t_reset();
    chk("R14 reset mode", read_mode, 0);
    chk("R14 reset reqs", {req_prog, req_sector, req_chip, req_suspend, req_resume}, 0);
  endtask

  task automatic t_ident();
    unlock(); wr(20'h00AAA, 16'h0090);
    chk("R2 ident mode", read_mode, 1);
    rd_chk("R12 id0", 8'h00, 16'h0001);
    rd_chk("R12 id1", 8'h02, 16'h227E);
    rd_chk("R12 word2 zero", 8'h04, 16'h0000);
    rd_chk("R12 id2", 8'h1C, 16'h2201);
    rd_chk("R12 id3 all-ones falls to array", 8'h1E, 16'hBEEF);
    rd_chk("R12 other word array", 8'h06, 16'hBEEF);
    wr(20'h0, 16'h00F0);
    chk("R7 reset from ident", read_mode, 0);
    rd_chk("R12 array mode read", 8'h00, 16'hBEEF);
  endtask

  task automatic t_alias();
    wr(20'h01AAA, 16'h00AA);
    wr(20'h01554, 16'h0055);
    wr(20'h00AAB, 16'h0090);
    chk("R1 aliased words accepted", read_mode, 1);
    wr(20'h0, 16'h00F0);
  endtask

  task automatic t_bad_seq();
    wr(20'h00AAA, 16'h00AA);
    wr(20'h00556, 16'h0055);
    wr(20'h00AAA, 16'h0090);
    chk("R3 bad unlock address resets", read_mode, 0);
    wr(20'h00AAA, 16'h00AA);
    wr(20'h00554, 16'h0056);
    wr(20'h00AAA, 16'h0090);
    chk("R3 bad unlock data resets", read_mode, 0);
  endtask

  task automatic t_program();
    arr_q = 16'hF0F0;
    unlock(); wr(20'h00AAA, 16'h00A0);
    chk("R2 program armed status", read_mode, 2);
    wr(20'h02000, 16'h3C5A);
    chk("R11 prog pulse", got, 5'b10000);
    chk("R11 prog addr", got_addr, 20'h02000);
    chk("R11 prog data AND", got_data, 16'h3050);
    chk("R11 back to array", read_mode, 0);
    @(negedge clk);
    chk("R14 prog pulse single", req_prog, 0);
    unlock(); wr(20'h00AAA, 16'h00A0);
    wr(20'h00010, 16'h00F0);
    chk("R7 F0 in program is data", got, 5'b10000);
    chk("R7 F0 data merged", got_data, 16'h00F0);
    arr_q = 16'hFFFF;
  endtask

  task automatic t_bypass();
    unlock(); wr(20'h00AAA, 16'h0020);
    chk("R5 bypass entry array", read_mode, 0);
    wr(20'h03000, 16'h00A0);
    chk("R5 bypass program armed", read_mode, 2);
    wr(20'h00040, 16'h1234);
    chk("R5 bypass prog 1", got, 5'b10000);
    wr(20'h00000, 16'h00A0);
    wr(20'h00042, 16'h0F0F);
    chk("R5 bypass prog 2", got, 5'b10000);
    chk("R5 bypass prog 2 addr", got_addr, 20'h00042);
    wr(20'h00000, 16'h0090);
    chk("R5 bypass ident", read_mode, 1);
    wr(20'h00000, 16'h0000);
    chk("R5 bypass exit", read_mode, 0);
    wr(20'h00000, 16'h00A0);
    wr(20'h00044, 16'h1111);
    chk("R5 no bypass after exit", got, 5'b00000);
    chk("R5 no bypass mode", read_mode, 0);
  endtask

  task automatic t_query();
    wr(20'h000AA, 16'h0098);
    chk("R6 query from read", read_mode, 3);
    rd_chk("R6 query data", 8'h20, 16'h0051);
    wr(20'h0, 16'h00F0);
    chk("R6 query back to read", read_mode, 0);
    unlock(); wr(20'h00AAA, 16'h0090);
    wr(20'h000AA, 16'h0098);
    chk("R6 query from ident", read_mode, 3);
    wr(20'h0, 16'h00F0);
    chk("R6 return to ident", read_mode, 1);
    wr(20'h0, 16'h00F0);
    chk("R6 then read", read_mode, 0);
    wr(20'h000AA, 16'h0098);
    wr(20'h0, 16'h0055);
    chk("R6 other write leaves query", read_mode, 0);
  endtask

  task automatic t_chip();
    erase_prefix(); wr(20'h00AAA, 16'h0010);
    chk("R4 chip req", got, 5'b00100);
    chk("R4 chip status", read_mode, 2);
    wr(20'h0, 16'h00F0);
    chk("R7 F0 ignored in chip erase", read_mode, 2);
    done_pulse();
    chk("R13 chip done", read_mode, 0);
    erase_prefix(); wr(20'h00010, 16'h0010);
    chk("R4 chip wrong addr no req", got, 5'b00000);
    chk("R4 chip wrong addr reset", read_mode, 0);
  endtask

  task automatic t_sector();
    erase_prefix(); wr(20'h08000, 16'h0030);
    chk("R4 sector req", got, 5'b01000);
    chk("R4 sector addr", got_addr, 20'h08000);
    chk("R4 sector status", read_mode, 2);
    eng_window = 1'b1;
    wr(20'h0C000, 16'h0030);
    chk("R8 queue sector", got, 5'b01000);
    chk("R8 queue addr", got_addr, 20'h0C000);
    wr(20'h0, 16'h00F0);
    chk("R8 other value in window resets", read_mode, 0);
    eng_window = 1'b0;
    erase_prefix(); wr(20'h08000, 16'h0030);
    wr(20'h0, 16'h0030);
    chk("R8 running ignores 30", got, 5'b00000);
    wr(20'h0, 16'h00F0);
    chk("R7 running ignores F0", read_mode, 2);
    wr(20'h0, 16'h00B0);
    chk("R8 suspend req", got, 5'b00010);
    chk("R8 suspend array", read_mode, 0);
  endtask

  task automatic t_suspended();
    eng_suspended = 1'b1;
    wr(20'h0, 16'h00B0);
    chk("R9 B0 ignored in read", got, 5'b00000);
    eng_sect_hit = 1'b1;
    unlock(); wr(20'h00AAA, 16'h00A0);
    wr(20'h08000, 16'h0000);
    chk("R10 program to erasing sector dropped", got, 5'b00000);
    eng_sect_hit = 1'b0;
    unlock(); wr(20'h00AAA, 16'h00A0);
    wr(20'h20000, 16'h0000);
    chk("R10 program elsewhere allowed", got, 5'b10000);
    erase_prefix(); wr(20'h09000, 16'h0030);
    chk("R10 erase while suspended no req", got, 5'b00000);
    chk("R10 erase while suspended reset", read_mode, 0);
    wr(20'h0, 16'h0030);
    chk("R9 resume req", got, 5'b00001);
    chk("R9 resume status", read_mode, 2);
    eng_suspended = 1'b0;
    done_pulse();
    chk("R13 sector done", read_mode, 0);
    wr(20'h0, 16'h0030);
    chk("R9 30 without suspend no req", got, 5'b00000);
    chk("R9 30 without suspend array", read_mode, 0);
  endtask

  task automatic t_collide();
    erase_prefix(); wr(20'h08000, 16'h0030);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 20'h0; wr_data = 16'h00B0; eng_done = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; eng_done = 1'b0;
    chk("R13 done beats suspend req", {req_prog, req_sector, req_chip, req_suspend, req_resume}, 0);
    chk("R13 done beats suspend mode", read_mode, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ident();
    t_alias();
    t_bad_seq();
    t_program();
    t_bypass();
    t_query();
    t_chip();
    t_sector();
    t_suspended();
    t_collide();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule